// File: doc/BRIEF.md
# Hashed Flow-Filter Table Command Controller

This block owns a bucketed table of flow filters and carries out single commands on it. A hash word has two fields. Its low `BKT_BITS` bits select a bucket and its remaining upper bits form the tag that identifies a filter inside that bucket. Software loads the hash word first and then issues one command: add (with an optional overwrite flag), query, or remove. The command field reads back the opcode while the operation is in flight and returns to zero when the operation is done. Software polls that field to detect completion.

The usable capacity follows from the configuration: `1 << (CAP_BASE + allocation code)` entries in perfect mode, and four times that in signature mode. Each bucket holds up to `WAYS` physical slots. A programmed per-bucket limit can cap the chain length below that. The block keeps counters for successful adds, failed adds, successful removes, failed removes and collisions, and it tracks the longest bucket length reached. A level interrupt is raised when free space falls to a programmed threshold. Packet lookup and hash computation sit outside this block.

Top module: `flow_table_cmd_ctrl`

## Requirements
- R1: A command with a nonzero opcode that is accepted while idle makes `cmd_field` read that opcode for exactly `LATENCY` cycles. `cmd_field` then reads 0, and all results and statistics are updated in the same cycle. Opcodes: 1 = add, 2 = query, 3 = remove.
- R2: A command presented while `cmd_field` is nonzero is ignored. The operation uses the hash word held at the moment its command was accepted. The hash word must be written at least one cycle before its command. Bucket = `hash[BKT_BITS-1:0]`, tag = the remaining upper bits.
- R3: An add of a tag that is not present in its bucket stores the action, increments the successful-add counter and lowers the free count by one.
- R4: An add of a tag already present fails without the update flag: the failed-add counter increments and the stored action is unchanged. With the update flag set, the add overwrites the stored action, counts as a success, and leaves the free count unchanged.
- R5: An add of a new tag fails and increments the failed-add counter when either of two conditions holds. The first is that the bucket already holds `min(cfg_max_len, WAYS)` entries. The second is that the free count is zero.
- R6: A query sets `filter_valid` to 1 and `qry_action` to the stored action when the tag is present. Otherwise it sets both to 0. Both hold their values until the next query completes. Action layout: bit 17 drop, bit 16 queue enable, bits 15:13 flow type, bits 12:7 pool, bits 6:0 receive queue.
- R7: A remove of a present tag deletes it, increments the successful-remove counter and raises the free count by one. A remove of an absent tag increments the failed-remove counter only.
- R8: `free_cnt` equals capacity minus stored entries, with a floor at 0. Capacity is `1 << (CAP_BASE + cfg_alloc)`, multiplied by 4 when `cfg_sig_mode` is 1.
- R9: `full_irq` is 1 exactly when `free_cnt <= cfg_full_thresh * THRESH_UNIT`.
- R10: Every successful new add into a bucket that already held an entry increments `coll_cnt`. `longest_len` is the largest bucket length reached by any successful add since reset.
- R11: After reset, all counters, `cmd_field`, `filter_valid` and `qry_action` are 0, and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_alloc | input | 2 | Allocation code for capacity |
| cfg_sig_mode | input | 1 | 1 = signature mode (capacity x4) |
| cfg_max_len | input | 4 | Per-bucket entry limit |
| cfg_full_thresh | input | 4 | Free threshold in units of THRESH_UNIT |
| hash_wr_en | input | 1 | Load hash word |
| hash_wr_data | input | BKT_BITS+TAG_BITS | Hash word (tag above bucket) |
| cmd_wr_en | input | 1 | Issue command |
| cmd_op | input | 2 | Opcode |
| cmd_update | input | 1 | Overwrite flag for add |
| cmd_action | input | 18 | Action to store on add |
| cmd_field | output | 2 | Opcode in flight, 0 when idle |
| filter_valid | output | 1 | Last query found the tag |
| qry_action | output | 18 | Action returned by last query |
| free_cnt | output | CAP_BASE+6 | Free entries |
| coll_cnt | output | CNT_W | Collision counter |
| longest_len | output | clog2(WAYS+1) | Longest bucket reached |
| add_ok_cnt | output | CNT_W | Successful adds |
| rem_ok_cnt | output | CNT_W | Successful removes |
| add_fail_cnt | output | CNT_W | Failed adds |
| rem_fail_cnt | output | CNT_W | Failed removes |
| full_irq | output | 1 | Free space at or below threshold |

## Verification
The bench builds the block with a 2-bit bucket index, a 6-bit tag, 4 ways, a capacity base of 2 and a threshold unit of 1. With these values, signature-mode capacity is 16, which equals the whole physical table. Full buckets, the way cap over a large programmed limit, capacity exhaustion, the zero floor after shrinking capacity, and the threshold crossing are therefore all reached within a few commands. Random commands over four tags per bucket produce frequent duplicates, updates and removes of absent tags.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int QUEUE_W  = 7;
    localparam int POOL_W   = 6;
    localparam int FLOW_W   = 3;
    localparam int ACT_W    = 2 + FLOW_W + POOL_W + QUEUE_W;
    localparam int MAXLEN_W = 4;
    localparam int THR_W    = 4;

    // statistic counter slots
    localparam int NSTAT       = 5;
    localparam int ST_ADD_OK   = 0;
    localparam int ST_ADD_FAIL = 1;
    localparam int ST_REM_OK   = 2;
    localparam int ST_REM_FAIL = 3;
    localparam int ST_COLL     = 4;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_ADD    = 2'd1,
        OP_QUERY  = 2'd2,
        OP_REMOVE = 2'd3
    } op_e;

    typedef struct packed {
        logic              drop;
        logic              queue_en;
        logic [FLOW_W-1:0] flow;
        logic [POOL_W-1:0] pool;
        logic [QUEUE_W-1:0] queue;
    } action_t;

    typedef struct packed {
        op_e     op;
        logic    update;
        action_t act;
    } cmd_t;

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ftc_sequencer.sv
module ftc_sequencer
    import ftc_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int HASH_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hash_wr_en,
    input  logic [HASH_W-1:0] hash_wr_data,
    input  logic              cmd_wr_en,
    input  cmd_t              cmd_in,
    output logic              busy,
    output logic              fire,
    output cmd_t              cmd_cur,
    output logic [HASH_W-1:0] hash_cur
);
    localparam int CW = idx_width(LATENCY);

    logic [CW-1:0]     cnt;
    logic [HASH_W-1:0] hash_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cmd_cur  <= '0;
            hash_q   <= '0;
            hash_cur <= '0;
        end else begin
            if (hash_wr_en) hash_q <= hash_wr_data;
            if (!busy) begin
                if (cmd_wr_en && cmd_in.op != OP_IDLE) begin
                    busy     <= 1'b1;
                    cnt      <= CW'(LATENCY - 1);
                    cmd_cur  <= cmd_in;
                    hash_cur <= hash_q;
                end
            end else if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign fire = busy && (cnt == '0);
endmodule

// File: rtl/ftc_way_scan.sv
module ftc_way_scan #(
    parameter int WAYS     = 10,
    parameter int TAG_BITS = 8,
    parameter int IDX_W    = 4,
    parameter int LEN_W    = 4
) (
    input  logic [WAYS-1:0]     valid,
    input  logic [TAG_BITS-1:0] tags [WAYS],
    input  logic [TAG_BITS-1:0] tag,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx,
    output logic [IDX_W-1:0]    free_idx,
    output logic [LEN_W-1:0]    occ
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        free_idx = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_idx = IDX_W'(w);
            if (!valid[w]) free_idx = IDX_W'(w);
        end
        occ = LEN_W'($countones(valid));
    end
endmodule

// File: rtl/ftc_stats.sv
module ftc_stats #(
    parameter int NCNT  = 5,
    parameter int CNT_W = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCNT-1:0]  inc,
    input  logic             len_upd,
    input  logic [LEN_W-1:0] len_new,
    output logic [CNT_W-1:0] cnt [NCNT],
    output logic [LEN_W-1:0] longest
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCNT; i++) cnt[i] <= '0;
            longest <= '0;
        end else begin
            for (int i = 0; i < NCNT; i++)
                if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
            if (len_upd && len_new > longest) longest <= len_new;
        end
    end
endmodule

// File: rtl/flow_table_cmd_ctrl.sv
module flow_table_cmd_ctrl
    import ftc_pkg::*;
#(
    parameter int BKT_BITS    = 3,
    parameter int TAG_BITS    = 8,
    parameter int WAYS        = 10,
    parameter int LATENCY     = 4,
    parameter int CAP_BASE    = 10,
    parameter int THRESH_UNIT = 16,
    parameter int CNT_W       = 16,
    localparam int HASH_W     = BKT_BITS + TAG_BITS,
    localparam int FREE_W     = CAP_BASE + 6,
    localparam int LEN_W      = $clog2(WAYS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_alloc,
    input  logic                cfg_sig_mode,
    input  logic [MAXLEN_W-1:0] cfg_max_len,
    input  logic [THR_W-1:0]    cfg_full_thresh,
    input  logic                hash_wr_en,
    input  logic [HASH_W-1:0]   hash_wr_data,
    input  logic                cmd_wr_en,
    input  logic [1:0]          cmd_op,
    input  logic                cmd_update,
    input  logic [ACT_W-1:0]    cmd_action,
    output logic [1:0]          cmd_field,
    output logic                filter_valid,
    output logic [ACT_W-1:0]    qry_action,
    output logic [FREE_W-1:0]   free_cnt,
    output logic [CNT_W-1:0]    coll_cnt,
    output logic [LEN_W-1:0]    longest_len,
    output logic [CNT_W-1:0]    add_ok_cnt,
    output logic [CNT_W-1:0]    rem_ok_cnt,
    output logic [CNT_W-1:0]    add_fail_cnt,
    output logic [CNT_W-1:0]    rem_fail_cnt,
    output logic                full_irq
);
    localparam int NBKT  = 1 << BKT_BITS;
    localparam int IDX_W = idx_width(WAYS);

    // command intake and latency
    cmd_t              cmd_in, cmd_cur;
    logic              busy, fire;
    logic [HASH_W-1:0] hash_cur;

    always_comb begin
        cmd_in.op     = op_e'(cmd_op);
        cmd_in.update = cmd_update;
        cmd_in.act    = action_t'(cmd_action);
    end

    ftc_sequencer #(.LATENCY(LATENCY), .HASH_W(HASH_W)) u_seq (
        .clk, .rst, .hash_wr_en, .hash_wr_data, .cmd_wr_en, .cmd_in,
        .busy, .fire, .cmd_cur, .hash_cur
    );

    assign cmd_field = busy ? cmd_cur.op : OP_IDLE;

    // table storage
    logic [WAYS-1:0]     tbl_valid [NBKT];
    logic [TAG_BITS-1:0] tbl_tag   [NBKT][WAYS];
    action_t             tbl_act   [NBKT][WAYS];

    logic [BKT_BITS-1:0] bkt;
    logic [TAG_BITS-1:0] tag;
    logic [TAG_BITS-1:0] scan_tags [WAYS];

    assign bkt = hash_cur[BKT_BITS-1:0];
    assign tag = hash_cur[HASH_W-1:BKT_BITS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) scan_tags[w] = tbl_tag[bkt][w];
    end

    logic             hit;
    logic [IDX_W-1:0] hit_idx, free_idx;
    logic [LEN_W-1:0] occ;

    ftc_way_scan #(.WAYS(WAYS), .TAG_BITS(TAG_BITS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_scan (
        .valid(tbl_valid[bkt]), .tags(scan_tags), .tag,
        .hit, .hit_idx, .free_idx, .occ
    );

    // capacity and free space
    logic [FREE_W-1:0] used_q, cap;
    assign cap      = FREE_W'(1) << (CAP_BASE + int'(cfg_alloc) + (cfg_sig_mode ? 2 : 0));
    assign free_cnt = (used_q >= cap) ? '0 : cap - used_q;
    assign full_irq = free_cnt <= FREE_W'(cfg_full_thresh) * FREE_W'(THRESH_UNIT);

    // outcome decode
    logic [LEN_W-1:0] eff_max;
    logic             is_add, is_qry, is_rem, add_new, add_ok;

    assign eff_max = (int'(cfg_max_len) > WAYS) ? LEN_W'(WAYS) : LEN_W'(cfg_max_len);
    assign is_add  = fire && cmd_cur.op == OP_ADD;
    assign is_qry  = fire && cmd_cur.op == OP_QUERY;
    assign is_rem  = fire && cmd_cur.op == OP_REMOVE;
    assign add_new = is_add && !hit && (occ < eff_max) && (free_cnt != '0);
    assign add_ok  = add_new || (is_add && hit && cmd_cur.update);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBKT; b++) tbl_valid[b] <= '0;
            used_q       <= '0;
            filter_valid <= 1'b0;
            qry_action   <= '0;
        end else begin
            if (add_new) begin
                tbl_valid[bkt][free_idx] <= 1'b1;
                used_q <= used_q + 1'b1;
            end
            if (is_rem && hit) begin
                tbl_valid[bkt][hit_idx] <= 1'b0;
                used_q <= used_q - 1'b1;
            end
            if (is_qry) begin
                filter_valid <= hit;
                qry_action   <= hit ? tbl_act[bkt][hit_idx] : '0;
            end
        end
    end

    // entry payload carries no reset
    always_ff @(posedge clk) begin
        if (add_new) begin
            tbl_tag[bkt][free_idx] <= tag;
            tbl_act[bkt][free_idx] <= cmd_cur.act;
        end else if (add_ok) begin
            tbl_act[bkt][hit_idx] <= cmd_cur.act;
        end
    end

    // statistics
    logic [NSTAT-1:0] st_inc;
    logic [CNT_W-1:0] st_cnt [NSTAT];

    always_comb begin
        st_inc              = '0;
        st_inc[ST_ADD_OK]   = add_ok;
        st_inc[ST_ADD_FAIL] = is_add && !add_ok;
        st_inc[ST_REM_OK]   = is_rem && hit;
        st_inc[ST_REM_FAIL] = is_rem && !hit;
        st_inc[ST_COLL]     = add_new && (occ != '0);
    end

    ftc_stats #(.NCNT(NSTAT), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_stats (
        .clk, .rst, .inc(st_inc), .len_upd(add_new), .len_new(occ + 1'b1),
        .cnt(st_cnt), .longest(longest_len)
    );

    assign add_ok_cnt   = st_cnt[ST_ADD_OK];
    assign add_fail_cnt = st_cnt[ST_ADD_FAIL];
    assign rem_ok_cnt   = st_cnt[ST_REM_OK];
    assign rem_fail_cnt = st_cnt[ST_REM_FAIL];
    assign coll_cnt     = st_cnt[ST_COLL];
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
    parameter int LATENCY = 4,
    parameter int WAYS    = 10,
    parameter int CNT_W   = 16,
    parameter int FREE_W  = 16,
    parameter int LEN_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd_field,
    input logic [1:0]        cfg_alloc,
    input logic              cfg_sig_mode,
    input logic [FREE_W-1:0] free_cnt,
    input logic [CNT_W-1:0]  add_ok_cnt,
    input logic [CNT_W-1:0]  add_fail_cnt,
    input logic [CNT_W-1:0]  rem_ok_cnt,
    input logic [CNT_W-1:0]  rem_fail_cnt,
    input logic [CNT_W-1:0]  coll_cnt,
    input logic [LEN_W-1:0]  longest_len
);
    localparam int RW = $clog2(LATENCY + 2) + 1;
    logic [RW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= '0;
        else if (cmd_field == 2'd0) busy_run <= '0;
        else if (busy_run != {RW{1'b1}}) busy_run <= busy_run + 1'b1;
    end

    // R1: the busy window never outlasts the command latency
    p_busy_window_r1: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RW'(LATENCY));

    // R1: statistics move only at a completion edge
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_field == 2'd0 |=> $stable(add_ok_cnt) && $stable(add_fail_cnt) &&
                              $stable(rem_ok_cnt) && $stable(rem_fail_cnt) && $stable(coll_cnt));

    // R2: the opcode in flight is never replaced by a later command
    p_op_held_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_field != 2'd0 |=> (cmd_field == $past(cmd_field) || cmd_field == 2'd0));

    // R7: one command yields exactly one outcome counter step at most
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
        $countones({add_ok_cnt != $past(add_ok_cnt), add_fail_cnt != $past(add_fail_cnt),
                    rem_ok_cnt != $past(rem_ok_cnt), rem_fail_cnt != $past(rem_fail_cnt)}) <= 1);

    // R8: with steady capacity, free space moves by at most one entry
    p_free_step_r8: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_alloc) && $stable(cfg_sig_mode) |->
            (free_cnt == $past(free_cnt) || free_cnt == $past(free_cnt) + 1'b1 ||
             free_cnt + 1'b1 == $past(free_cnt)));

    // R10: longest bucket is a high-water mark bounded by the ways
    p_longest_mono_r10: assert property (@(posedge clk) disable iff (rst)
        longest_len >= $past(longest_len) && longest_len <= LEN_W'(WAYS));
endmodule

bind flow_table_cmd_ctrl ftc_checker #(
    .LATENCY(LATENCY), .WAYS(WAYS), .CNT_W(CNT_W), .FREE_W(FREE_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst(rst), .cmd_field(cmd_field), .cfg_alloc(cfg_alloc),
    .cfg_sig_mode(cfg_sig_mode), .free_cnt(free_cnt), .add_ok_cnt(add_ok_cnt),
    .add_fail_cnt(add_fail_cnt), .rem_ok_cnt(rem_ok_cnt), .rem_fail_cnt(rem_fail_cnt),
    .coll_cnt(coll_cnt), .longest_len(longest_len)
);

// File: tb/flow_table_cmd_ctrl_bench.sv
module flow_table_cmd_ctrl_bench;
    import ftc_pkg::*;

    localparam int BKT = 2, TAGB = 6, WAYS = 4, LAT = 4, CAPB = 2, TUNIT = 1, CNT_W = 16;
    localparam int HASH_W = BKT + TAGB, FREE_W = CAPB + 6, LEN_W = $clog2(WAYS + 1);
    localparam int NB = 1 << BKT, NH = 1 << HASH_W;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] cfg_alloc = 2'd0;
    logic cfg_sig_mode = 1'b1;
    logic [3:0] cfg_max_len = 4'd4, cfg_full_thresh = 4'd2;
    logic hash_wr_en = 1'b0, cmd_wr_en = 1'b0, cmd_update = 1'b0;
    logic [HASH_W-1:0] hash_wr_data = '0;
    logic [1:0] cmd_op = 2'd0;
    logic [ACT_W-1:0] cmd_action = '0;
    logic [1:0] cmd_field;
    logic filter_valid, full_irq;
    logic [ACT_W-1:0] qry_action;
    logic [FREE_W-1:0] free_cnt;
    logic [CNT_W-1:0] coll_cnt, add_ok_cnt, rem_ok_cnt, add_fail_cnt, rem_fail_cnt;
    logic [LEN_W-1:0] longest_len;

    flow_table_cmd_ctrl #(.BKT_BITS(BKT), .TAG_BITS(TAGB), .WAYS(WAYS), .LATENCY(LAT),
        .CAP_BASE(CAPB), .THRESH_UNIT(TUNIT), .CNT_W(CNT_W)) u_flow_table_cmd_ctrl (.*);

    always #4 clk = ~clk;

    bit m_valid [NH];
    logic [ACT_W-1:0] m_act [NH];
    int e_used, e_add_ok, e_add_fail, e_rem_ok, e_rem_fail, e_coll, e_long;
    bit e_qv;
    logic [ACT_W-1:0] e_qa;
    int n_chk, n_fail;
    bit finished;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cap_f();
        return (1 << (CAPB + int'(cfg_alloc))) << (cfg_sig_mode ? 2 : 0);
    endfunction

    function automatic int free_f();
        return (e_used >= cap_f()) ? 0 : cap_f() - e_used;
    endfunction

    function automatic int occ_f(int b);
        int n = 0;
        for (int t = 0; t < NH / NB; t++) if (m_valid[t * NB + b]) n++;
        return n;
    endfunction

    function automatic void model(input int op, input int h, input logic [ACT_W-1:0] a, input bit upd);
        bit hit = m_valid[h];
        int occ = occ_f(h % NB);
        int emax = (int'(cfg_max_len) > WAYS) ? WAYS : int'(cfg_max_len);
        case (op)
            1: if (hit) begin
                   if (upd) begin m_act[h] = a; e_add_ok++; end
                   else e_add_fail++;
               end else if (occ < emax && free_f() != 0) begin
                   m_valid[h] = 1'b1; m_act[h] = a; e_used++; e_add_ok++;
                   if (occ > 0) e_coll++;
                   if (occ + 1 > e_long) e_long = occ + 1;
               end else e_add_fail++;
            2: begin e_qv = hit; e_qa = hit ? m_act[h] : '0; end
            3: if (hit) begin m_valid[h] = 1'b0; e_used--; e_rem_ok++; end
               else e_rem_fail++;
            default: ;
        endcase
    endfunction

    task automatic compare_all();
        chk("R3", "add_ok_cnt", add_ok_cnt, e_add_ok);
        chk("R5", "add_fail_cnt", add_fail_cnt, e_add_fail);
        chk("R7", "rem_ok_cnt", rem_ok_cnt, e_rem_ok);
        chk("R7", "rem_fail_cnt", rem_fail_cnt, e_rem_fail);
        chk("R8", "free_cnt", free_cnt, free_f());
        chk("R9", "full_irq", full_irq, (free_f() <= int'(cfg_full_thresh) * TUNIT) ? 1 : 0);
        chk("R10", "coll_cnt", coll_cnt, e_coll);
        chk("R10", "longest_len", longest_len, e_long);
        chk("R6", "filter_valid", filter_valid, e_qv);
        chk("R6", "qry_action", qry_action, e_qa);
    endtask

    task automatic wait_idle(output int bc);
        bc = 0;
        while (cmd_field != 2'd0 && bc < 100) begin bc++; @(negedge clk); end
    endtask

    task automatic run_cmd(input int op, input int h, input logic [ACT_W-1:0] a, input bit upd);
        int bc;
        model(op, h, a, upd);
        @(negedge clk); hash_wr_en = 1'b1; hash_wr_data = HASH_W'(h);
        @(negedge clk); hash_wr_en = 1'b0; cmd_wr_en = 1'b1; cmd_op = 2'(op);
        cmd_update = upd; cmd_action = a;
        @(negedge clk); cmd_wr_en = 1'b0; cmd_op = 2'd0; cmd_update = 1'b0;
        wait_idle(bc);
        chk("R1", "busy cycles", bc, LAT);
        compare_all();
    endtask

    function automatic int hsh(int tag, int b);
        return tag * NB + b;
    endfunction

    localparam logic [ACT_W-1:0] A1 = 18'h2_0A55, A2 = 18'h1_3C07;

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "cmd_field", cmd_field, 0);
        chk("R11", "free_cnt", free_cnt, 16);
        chk("R11", "counters", add_ok_cnt + add_fail_cnt + rem_ok_cnt + rem_fail_cnt + coll_cnt, 0);
        chk("R11", "filter_valid", filter_valid, 0);
        chk("R11", "qry_action", qry_action, 0);
        chk("R11", "longest_len", longest_len, 0);

        // R3 new add, R4 duplicate and update
        run_cmd(1, hsh(1, 0), A1, 1'b0);
        run_cmd(1, hsh(1, 0), A2, 1'b0);
        run_cmd(2, hsh(1, 0), '0, 1'b0);
        chk("R4", "action kept after duplicate add", qry_action, A1);
        run_cmd(1, hsh(1, 0), A2, 1'b1);
        run_cmd(2, hsh(1, 0), '0, 1'b0);
        chk("R4", "action after update", qry_action, A2);
        chk("R4", "free after update", free_cnt, 15);

        // R2 command during busy is dropped
        begin
            int bc;
            model(1, hsh(5, 1), A1, 1'b0);
            @(negedge clk); hash_wr_en = 1'b1; hash_wr_data = HASH_W'(hsh(5, 1));
            @(negedge clk); hash_wr_en = 1'b0; cmd_wr_en = 1'b1; cmd_op = 2'd1; cmd_action = A1;
            @(negedge clk); hash_wr_en = 1'b1; hash_wr_data = HASH_W'(hsh(6, 1)); cmd_action = A2;
            @(negedge clk); hash_wr_en = 1'b0; cmd_wr_en = 1'b0; cmd_op = 2'd0;
            wait_idle(bc);
            chk("R2", "busy cycles with extra command", bc, LAT - 1);
            compare_all();
            run_cmd(2, hsh(6, 1), '0, 1'b0);
            chk("R2", "ignored add absent", filter_valid, 0);
            run_cmd(2, hsh(5, 1), '0, 1'b0);
            chk("R2", "accepted add present", filter_valid, 1);
        end

        // R5 bucket limit from programmed length, then from ways
        cfg_max_len = 4'd2;
        run_cmd(1, hsh(2, 0), A1, 1'b0);
        run_cmd(1, hsh(3, 0), A1, 1'b0);
        chk("R5", "third add into limit-2 bucket", add_fail_cnt, 1 + 1);
        cfg_max_len = 4'd9;
        run_cmd(1, hsh(3, 0), A1, 1'b0);
        run_cmd(1, hsh(4, 0), A1, 1'b0);
        run_cmd(1, hsh(7, 0), A1, 1'b0);
        chk("R5", "way cap below programmed limit", longest_len, 4);

        // R7 remove absent and present
        run_cmd(3, hsh(9, 2), '0, 1'b0);
        run_cmd(3, hsh(4, 0), '0, 1'b0);
        run_cmd(2, hsh(4, 0), '0, 1'b0);
        chk("R7", "removed entry gone", filter_valid, 0);

        // R8 R9 capacity shrink and floor
        cfg_sig_mode = 1'b0;
        @(negedge clk);
        chk("R8", "free floored at zero", free_cnt, 0);
        chk("R9", "irq at zero free", full_irq, 1);
        run_cmd(1, hsh(8, 3), A1, 1'b0);
        cfg_alloc = 2'd1;
        @(negedge clk);
        chk("R8", "capacity 8 free", free_cnt, 8 - e_used);
        run_cmd(1, hsh(8, 3), A2, 1'b0);
        run_cmd(1, hsh(9, 3), A2, 1'b0);
        chk("R9", "irq at threshold", full_irq, 1);
        run_cmd(3, hsh(9, 3), '0, 1'b0);
        chk("R9", "irq clear above threshold", full_irq, 0);

        // random mix
        cfg_sig_mode = 1'b1; cfg_alloc = 2'd0; cfg_max_len = 4'd3;
        for (int i = 0; i < 400; i++) begin
            if (i % 80 == 79) cfg_max_len = 4'(1 + $urandom % 6);
            if (i % 130 == 129) cfg_full_thresh = 4'($urandom % 16);
            run_cmd(1 + int'($urandom % 3), hsh(int'($urandom % 4), int'($urandom % NB)),
                    ACT_W'($urandom), 1'($urandom % 2));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule